// File: doc/BRIEF.md
# Dual-Output PWM Slice with Fractional Clock Divider

This block produces two pulse-width-modulated outputs from one shared 16-bit counter. A fractional clock divider with an 8-bit integer part and a 4-bit fraction turns the system clock into count ticks. On each tick the counter steps up by one. When it reaches the programmed wrap value it returns to zero, so one period lasts wrap+1 ticks. Each output compares the counter with its own duty field and is high while the counter is below that field. Because both outputs share the divider and the wrap value, they always have the same period and differ only in duty.

Software programs the slice through a small write port and a combinational read port. Wrap and duty writes go to shadow copies. While the slice runs, the active copies take these values only when the counter wraps, so a change in mid-period never cuts a pulse short. While the slice is halted, the active copies follow the shadows on every cycle.

Control is a two-state machine. `ST_HALT` holds the counter and the divider phase and drives both outputs low. `ST_COUNT` runs the divider and the counter. The transition *start* (`ST_HALT` to `ST_COUNT`) takes place on a control write with bit 0 set. The transition *stop* (`ST_COUNT` to `ST_HALT`) takes place on a control write with bit 0 clear. Both transitions take effect at the clock edge that accepts the write.

Top module: `pwm_slice`

## Requirements
- R1: After reset, the register reads are as follows: control reads 0, divider reads 0x010, counter reads 0, compare reads 0, and wrap reads 0xFFFF. Both outputs are low.
- R2: While halted, the counter holds its value and both outputs stay low, whatever the compare values are.
- R3: The divider register holds an 8.4 fixed-point value D. When bits 11:4 are nonzero, c clock edges after the start edge the counter equals floor(16·c/D) mod (wrap+1), given a counter of 0 at start.
- R4: A divider value whose integer part (bits 11:4) is zero acts as 256 plus its fraction. So 0x000 gives one tick per 256 clocks, 0x008 gives none within 256 clocks, and 0xFFF gives two ticks within 512 clocks.
- R5: The counter steps from 0 up to the wrap value and then returns to 0, so a period is wrap+1 ticks.
- R6: Output A is high exactly when the slice runs and counter < compare A. Output B does the same with compare B. A compare of 0 keeps the output low, and a compare above the wrap value keeps it high.
- R7: While running, writes to the wrap or compare registers take effect only once the counter wraps back to 0.
- R8: A compare write carries a 2-bit field mask: bit 0 updates field A (data bits 15:0), bit 1 updates field B (data bits 31:16). A field whose mask bit is clear keeps its value.
- R9: A counter write loads the counter at that edge, both when halted and when running.
- R10: Register addresses are 0 for control (bit 0 is the enable bit), 1 for the divider, 2 for the counter, 3 for compare, and 4 for wrap. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| wr_field | input | 2 | Compare field mask (bit 0 = A, bit 1 = B) |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Read data (combinational) |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
A wrong divider phase shows up in the counter read-back within a few periods of D/16 clocks, as a value that departs from floor(16·c/D). A bad wrap or a shadow value loaded at the wrong time shows up within one period. The counter then either passes the expected wrap value or the outputs switch at the wrong count before the wrap. A state machine stuck in the wrong state shows up on the next clock, as a counter that moves while halted or an output that goes high while halted.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
    typedef enum logic [2:0] {
        REG_CTL = 3'd0,
        REG_DIV = 3'd1,
        REG_CTR = 3'd2,
        REG_CMP = 3'd3,
        REG_TOP = 3'd4
    } reg_addr_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;
endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [INT_W+FRAC_W-1:0] div,
    output logic                    tick
);
    localparam int DIV_W = INT_W + FRAC_W;
    localparam int ACC_W = DIV_W + 2;

    logic [ACC_W-1:0] acc_q, sum, eff;

    // zero integer part means the largest integer step plus the fraction
    always_comb begin
        if (div[DIV_W-1:FRAC_W] == '0)
            eff = (ACC_W'(1) << DIV_W) | ACC_W'(div[FRAC_W-1:0]);
        else
            eff = ACC_W'(div);
        sum  = acc_q + (ACC_W'(1) << FRAC_W);
        tick = run && (sum >= eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (!run)   acc_q <= '0;
        else if (tick)   acc_q <= sum - eff;
        else             acc_q <= sum;
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      tick,
    input  logic                      ctr_wr,
    input  logic [CNT_W-1:0]          ctr_wdata,
    input  logic [CNT_W-1:0]          top_sh,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_sh,
    output logic [CNT_W-1:0]          ctr,
    output logic [CNT_W-1:0]          top_act,
    output logic [NCH-1:0][CNT_W-1:0] cmp_act,
    output logic                      wrap
);
    assign wrap = tick && (ctr == top_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctr <= '0;
        else if (ctr_wr) ctr <= ctr_wdata;
        else if (wrap)   ctr <= '0;
        else if (tick)   ctr <= ctr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_act <= '1;
            cmp_act <= '0;
        end else if (!run || wrap) begin
            top_act <= top_sh;
            cmp_act <= cmp_sh;
        end
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic                      run,
    input  logic [CNT_W-1:0]          ctr,
    input  logic [NCH-1:0][CNT_W-1:0] cmp_act,
    output logic [NCH-1:0]            level
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign level[ch] = run && (ctr < cmp_act[ch]);
    end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DIV_INT_W  = 8,
    parameter int DIV_FRAC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [2*CNT_W-1:0] wr_data,
    input  logic [1:0]         wr_field,
    input  logic [2:0]         rd_addr,
    output logic [2*CNT_W-1:0] rd_data,
    output logic               pwm_a,
    output logic               pwm_b
);
    localparam int NCH    = 2;
    localparam int DIV_W  = DIV_INT_W + DIV_FRAC_W;
    localparam int DATA_W = NCH * CNT_W;

    run_state_e               state_q, state_d;
    logic                     run;
    logic                     ctl_wr, div_wr, ctr_wr, cmp_wr, top_wr;
    logic [DIV_W-1:0]         div_q;
    logic [CNT_W-1:0]         top_sh;
    logic [NCH-1:0][CNT_W-1:0] cmp_sh;
    logic                     tick, wrap;
    logic [CNT_W-1:0]         ctr, top_act;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    logic [NCH-1:0]           level;

    always_comb begin
        ctl_wr = wr_en && (wr_addr == REG_CTL);
        div_wr = wr_en && (wr_addr == REG_DIV);
        ctr_wr = wr_en && (wr_addr == REG_CTR);
        cmp_wr = wr_en && (wr_addr == REG_CMP);
        top_wr = wr_en && (wr_addr == REG_TOP);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // transitions: start and stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctl_wr && wr_data[0])  state_d = ST_COUNT;
            ST_COUNT: if (ctl_wr && !wr_data[0]) state_d = ST_HALT;
        endcase
    end

    assign run = (state_q == ST_COUNT);

    // configuration shadows
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= DIV_W'(1) << DIV_FRAC_W;
            top_sh <= '1;
        end else begin
            if (div_wr) div_q  <= wr_data[DIV_W-1:0];
            if (top_wr) top_sh <= wr_data[CNT_W-1:0];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    cmp_sh[ch] <= '0;
            else if (cmp_wr && wr_field[ch]) cmp_sh[ch] <= wr_data[ch*CNT_W +: CNT_W];
        end
    end

    pwm_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .ctr_wr(ctr_wr), .ctr_wdata(wr_data[CNT_W-1:0]),
        .top_sh(top_sh), .cmp_sh(cmp_sh),
        .ctr(ctr), .top_act(top_act), .cmp_act(cmp_act), .wrap(wrap)
    );

    pwm_compare #(.CNT_W(CNT_W), .NCH(NCH)) u_cmp (
        .run(run), .ctr(ctr), .cmp_act(cmp_act), .level(level)
    );

    // outputs
    always_comb begin
        pwm_a = level[0];
        pwm_b = level[1];
        rd_data = '0;
        unique case (reg_addr_e'(rd_addr))
            REG_CTL: rd_data = DATA_W'(run);
            REG_DIV: rd_data = DATA_W'(div_q);
            REG_CTR: rd_data = DATA_W'(ctr);
            REG_CMP: rd_data = cmp_sh;
            REG_TOP: rd_data = DATA_W'(top_sh);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
    parameter int CNT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    run,
    input logic                    tick,
    input logic                    wrap,
    input logic                    ctr_wr,
    input logic [CNT_W-1:0]        ctr,
    input logic [CNT_W-1:0]        top_act,
    input logic [1:0][CNT_W-1:0]   cmp_act,
    input logic                    pwm_a,
    input logic                    pwm_b
);
    p_halt_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm_a && !pwm_b));

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ctr_wr) |=> $stable(ctr));

    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !ctr_wr) |=> $stable(ctr));

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (ctr == top_act) && !ctr_wr) |=> (ctr == '0));

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(top_act) && $stable(cmp_act)));

    p_zero_cmp_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_act[0] == '0) |-> !pwm_a) and ((cmp_act[1] == '0) |-> !pwm_b));
endmodule

bind pwm_slice pwm_slice_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wrap(wrap),
    .ctr_wr(ctr_wr), .ctr(ctr), .top_act(top_act), .cmp_act(cmp_act),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/test_pwm_slice.sv
module test_pwm_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_field = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pwm_a, pwm_b;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [2:0] A_CTL = 3'd0, A_DIV = 3'd1, A_CTR = 3'd2, A_CMP = 3'd3, A_TOP = 3'd4;

    always #2 clk = ~clk;

    pwm_slice i_pwm_slice (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_field(wr_field), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] f);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_field = f;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_ctr(input int v, output bit found);
        logic [31:0] r;
        found = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            rd(A_CTR, r);
            if (r == 32'(v)) begin found = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // expected counter value from R3/R4/R5
    function automatic int exp_ctr(int d, int c, int top);
        int eff;
        eff = ((d >> 4) == 0) ? (4096 + (d & 15)) : d;
        return ((16 * c) / eff) % (top + 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        bit found;
        void'($urandom(32'd4242));
        #7 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTL, v); chk("R1 ctl", v, 32'h0);
        rd(A_DIV, v); chk("R1 div", v, 32'h010);
        rd(A_CTR, v); chk("R1 ctr", v, 32'h0);
        rd(A_CMP, v); chk("R1 cmp", v, 32'h0);
        rd(A_TOP, v); chk("R1 top", v, 32'hFFFF);
        rd(3'd6, v);  chk("R10 unmapped", v, 32'h0);
        chk("R1 outs", {30'd0, pwm_a, pwm_b}, 32'h0);

        // R8 field mask
        wr(A_CMP, 32'h1111_2222, 2'b11);
        wr(A_CMP, 32'hAAAA_BBBB, 2'b01);
        rd(A_CMP, v); chk("R8 mask A only", v, 32'h1111_BBBB);
        wr(A_CMP, 32'hCCCC_DDDD, 2'b10);
        rd(A_CMP, v); chk("R8 mask B only", v, 32'hCCCC_BBBB);
        wr(A_CMP, 32'h5555_6666, 2'b00);
        rd(A_CMP, v); chk("R8 empty mask", v, 32'hCCCC_BBBB);

        // R2 halted with high compares
        repeat (10) @(negedge clk);
        rd(A_CTR, v); chk("R2 halted ctr", v, 32'h0);
        chk("R2 halted outs", {30'd0, pwm_a, pwm_b}, 32'h0);

        // R9 counter write while halted
        wr(A_CTR, 32'd7, 2'b00);
        rd(A_CTR, v); chk("R9 halted load", v, 32'd7);

        // random runs: R3 R5 R6
        for (int it = 0; it < 24; it++) begin
            int d, top, ca, cb, c, e;
            d   = 16 + int'($urandom % 128);
            top = 1 + int'($urandom % 15);
            ca  = int'($urandom % 17);
            cb  = int'($urandom % 17);
            c   = 1 + int'($urandom % 200);
            wr(A_CTL, 32'd0, 2'b00);
            wr(A_CTR, 32'd0, 2'b00);
            wr(A_DIV, 32'(d), 2'b00);
            wr(A_TOP, 32'(top), 2'b00);
            wr(A_CMP, {16'(cb), 16'(ca)}, 2'b11);
            wr(A_CTL, 32'd1, 2'b00);
            repeat (c) @(negedge clk);
            e = exp_ctr(d, c, top);
            rd(A_CTR, v); chk("R3/R5 counter", v, 32'(e));
            chk("R6 out A", {31'd0, pwm_a}, {31'd0, e < ca});
            chk("R6 out B", {31'd0, pwm_b}, {31'd0, e < cb});
        end

        // R4 zero integer part
        begin
            int dl[3] = '{0, 8, 4095};
            int cl[3] = '{256, 256, 512};
            for (int k = 0; k < 3; k++) begin
                wr(A_CTL, 32'd0, 2'b00);
                wr(A_CTR, 32'd0, 2'b00);
                wr(A_TOP, 32'hFFFF, 2'b00);
                wr(A_DIV, 32'(dl[k]), 2'b00);
                wr(A_CTL, 32'd1, 2'b00);
                repeat (cl[k]) @(negedge clk);
                rd(A_CTR, v); chk("R4 large divider", v, 32'(exp_ctr(dl[k], cl[k], 65535)));
            end
        end

        // R6 compare above wrap, then R2 stop holds
        wr(A_CTL, 32'd0, 2'b00);
        wr(A_CTR, 32'd0, 2'b00);
        wr(A_DIV, 32'h010, 2'b00);
        wr(A_TOP, 32'd20, 2'b00);
        wr(A_CMP, 32'hFFFF_FFFF, 2'b11);
        wr(A_CTL, 32'd1, 2'b00);
        repeat (5) @(negedge clk);
        chk("R6 cmp above top", {30'd0, pwm_a, pwm_b}, 32'h3);
        // R9 counter write while running
        wr(A_CTR, 32'd15, 2'b00);
        rd(A_CTR, v); chk("R9 running load", v, 32'd15);
        wr(A_CTL, 32'd0, 2'b00);
        rd(A_CTR, v);
        repeat (30) @(negedge clk);
        rd(A_CTR, v2); chk("R2 stop holds ctr", v2, v);
        chk("R2 stop outs low", {30'd0, pwm_a, pwm_b}, 32'h0);
        rd(A_CTL, v); chk("R10 ctl reads halted", v, 32'h0);

        // R7 shadow load at wrap
        wr(A_CTR, 32'd0, 2'b00);
        wr(A_TOP, 32'd9, 2'b00);
        wr(A_CMP, 32'h0000_0005, 2'b11);
        wr(A_CTL, 32'd1, 2'b00);
        wait_ctr(2, found);
        wr(A_CMP, 32'h0000_0001, 2'b01);
        rd(A_CTR, v); chk("R7 ctr after cmp write", v, 32'd4);
        chk("R7 old cmp still active", {31'd0, pwm_a}, 32'd1);
        wr(A_TOP, 32'd4, 2'b00);
        wait_ctr(9, found);
        chk("R7 old top still active", {31'd0, found}, 32'd1);
        @(negedge clk);
        rd(A_CTR, v); chk("R7 wrap to zero", v, 32'd0);
        @(negedge clk);
        rd(A_CTR, v); chk("R7 ctr one", v, 32'd1);
        chk("R7 new cmp active", {31'd0, pwm_a}, 32'd0);
        wait_ctr(4, found);
        @(negedge clk);
        rd(A_CTR, v); chk("R7 new top active", v, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule